// File: doc/BRIEF.md
# Transmit Error Recovery Supervisor

This block watches one Ethernet transmit attempt at a time and decides how the transmit path recovers when the attempt goes wrong. It measures how far each attempt has progressed by counting bit-time ticks from the start of the preamble. With that count it separates ordinary collisions, which are handed to an external backoff path, from late collisions, which it handles itself. It also reacts to a transmit FIFO that runs dry mid-frame, and it flags any attempt that starts while the link is down.

Two enables choose the recovery policy. With late-collision retry enabled, a late-collided frame is retried until the attempt limit is reached. With underflow retransmit enabled, an underflowed frame is kept and restarted once it is fully buffered. Either enable being low makes the block drop the frame and move on. The block drives short command pulses: abort, retry, next frame, FCS inversion, and increment strobes for three statistics counters.

Top module: `txerr_supervisor`

## Requirements
- R1: After reset every output is low and the block is idle, waiting for a preamble-start strobe.
- R2: A preamble-start strobe taken while idle with `link_up_i` low produces a one-cycle `inc_lost_carrier_o` pulse in the next cycle. The attempt proceeds normally. With the link up, no such pulse occurs.
- R3: A collision is late only when `half_duplex_i` is high and at least SLOT_BITS (512) bit-time ticks have been counted since the preamble-start strobe. The tick counter saturates at that value. A half-duplex collision before that point produces a `normal_collision_o` pulse and returns the block to idle. A collision in full-duplex mode has no effect.
- R4: Every late collision produces, in the next cycle, a one-cycle pulse on both `inc_late_collision_o` and `abort_o`.
- R5: With `late_retry_en_i` low, a late collision also pulses `next_frame_o` and never `retry_o`.
- R6: With `late_retry_en_i` high, late collisions on attempts 1 to 15 pulse `retry_o`. The 16th consecutive late-collided attempt pulses `next_frame_o` instead and clears the attempt count, so the next frame again gets 16 attempts. Any `next_frame_o` also clears the count.
- R7: When `fifo_dry_i` is seen during an attempt, the next cycle carries one-cycle pulses on `invert_fcs_o`, `inc_underrun_o` and `abort_o`. FIFO underflow takes priority over a collision or completion in the same cycle.
- R8: With `underflow_rexmit_en_i` high, an underflow issues no `next_frame_o`. The block then waits, ignoring preamble-start strobes, until `frame_buffered_i` is high, and then pulses `retry_o` once.
- R9: With `underflow_rexmit_en_i` low, an underflow also pulses `next_frame_o`, and the frame is not retried.
- R10: `tx_done_i` during an attempt pulses `next_frame_o` and returns the block to idle.
- R11: Every output is a single-cycle pulse, low in the cycle after it is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick_i | input | 1 | One pulse per bit time |
| preamble_start_i | input | 1 | First preamble bit of an attempt begins |
| collision_i | input | 1 | Collision detected on the medium |
| fifo_dry_i | input | 1 | Transmit FIFO emptied mid-frame |
| frame_buffered_i | input | 1 | Whole frame is held in the FIFO |
| tx_done_i | input | 1 | Attempt completed without error |
| link_up_i | input | 1 | Link status, high when up |
| half_duplex_i | input | 1 | Half-duplex operation |
| late_retry_en_i | input | 1 | Retry late-collided frames |
| underflow_rexmit_en_i | input | 1 | Keep and restart underflowed frames |
| abort_o | output | 1 | Abort current attempt |
| retry_o | output | 1 | Restart the same frame |
| next_frame_o | output | 1 | Move on to the next frame |
| invert_fcs_o | output | 1 | Append an inverted FCS |
| inc_lost_carrier_o | output | 1 | Lost-carrier counter increment |
| inc_late_collision_o | output | 1 | Late-collision counter increment |
| inc_underrun_o | output | 1 | Underrun counter increment |
| normal_collision_o | output | 1 | Early collision for external backoff |

## Verification
The embedded properties check on every cycle that the strobes never last two cycles, that late collisions only follow a half-duplex collision, and that retry and next-frame never coincide. They also check that an underrun always carries FCS inversion and abort, and that the tick and attempt counters stay in range. Some behaviour can only be shown by the bench's scenarios: where the 512-tick boundary falls, the exact 16-attempt limit and the count being cleared afterwards, the wait for full buffering before a retransmit, and full-duplex collisions being ignored.

// File: rtl/txerr_pkg.sv
package txerr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_HOLD = 2'd2
  } txe_state_e;

  typedef struct packed {
    logic abort;
    logic retry;
    logic next_frame;
    logic invert_fcs;
    logic lost_carrier;
    logic late_col;
    logic underrun;
    logic normal_col;
  } txe_cmd_t;

endpackage

// File: rtl/txe_slot_timer.sv
module txe_slot_timer #(
  parameter int SLOT_BITS = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int CW = $clog2(SLOT_BITS + 1);
  localparam logic [CW-1:0] SLOT_V = CW'(SLOT_BITS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear_i || (tick_i && (cnt_q != SLOT_V));
    cnt_d  = clear_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == SLOT_V);

  p_timer_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SLOT_V);
  p_timer_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !tick_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/txe_attempt_tracker.sv
module txe_attempt_tracker #(
  parameter int MAX_TRIES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bump_i,
  input  logic wipe_i,
  output logic final_try_o
);
  localparam int AW = $clog2(MAX_TRIES + 1);
  localparam logic [AW-1:0] LAST_V = AW'(MAX_TRIES - 1);

  logic [AW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = wipe_i || bump_i;
    cnt_d  = wipe_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign final_try_o = (cnt_q == LAST_V);

  p_attempt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_V);
  p_no_bump_at_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bump_i && !wipe_i) |-> (cnt_q != LAST_V));
endmodule

// File: rtl/txerr_supervisor.sv
module txerr_supervisor
  import txerr_pkg::*;
#(
  parameter int SLOT_BITS = 512,
  parameter int MAX_TRIES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick_i,
  input  logic preamble_start_i,
  input  logic collision_i,
  input  logic fifo_dry_i,
  input  logic frame_buffered_i,
  input  logic tx_done_i,
  input  logic link_up_i,
  input  logic half_duplex_i,
  input  logic late_retry_en_i,
  input  logic underflow_rexmit_en_i,
  output logic abort_o,
  output logic retry_o,
  output logic next_frame_o,
  output logic invert_fcs_o,
  output logic inc_lost_carrier_o,
  output logic inc_late_collision_o,
  output logic inc_underrun_o,
  output logic normal_collision_o
);

  txe_state_e state_q, state_d;
  txe_cmd_t   cmd_q, cmd_d;
  logic       timer_clr, slot_expired;
  logic       try_bump, try_wipe, final_try;

  txe_slot_timer #(.SLOT_BITS(SLOT_BITS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (timer_clr),
    .tick_i    (bit_tick_i),
    .expired_o (slot_expired)
  );

  txe_attempt_tracker #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk         (clk),
    .rst_n       (rst_n),
    .bump_i      (try_bump),
    .wipe_i      (try_wipe),
    .final_try_o (final_try)
  );

  always_comb begin
    state_d   = state_q;
    cmd_d     = '0;
    timer_clr = 1'b0;
    try_bump  = 1'b0;
    try_wipe  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (preamble_start_i) begin
          timer_clr          = 1'b1;
          cmd_d.lost_carrier = !link_up_i;
          state_d            = ST_SEND;
        end
      end
      ST_SEND: begin
        if (fifo_dry_i) begin
          cmd_d.abort      = 1'b1;
          cmd_d.invert_fcs = 1'b1;
          cmd_d.underrun   = 1'b1;
          if (underflow_rexmit_en_i) begin
            state_d = ST_HOLD;
          end else begin
            cmd_d.next_frame = 1'b1;
            try_wipe         = 1'b1;
            state_d          = ST_IDLE;
          end
        end else if (collision_i && half_duplex_i) begin
          state_d = ST_IDLE;
          if (slot_expired) begin
            cmd_d.abort    = 1'b1;
            cmd_d.late_col = 1'b1;
            if (late_retry_en_i && !final_try) begin
              cmd_d.retry = 1'b1;
              try_bump    = 1'b1;
            end else begin
              cmd_d.next_frame = 1'b1;
              try_wipe         = 1'b1;
            end
          end else begin
            cmd_d.normal_col = 1'b1;
          end
        end else if (tx_done_i) begin
          cmd_d.next_frame = 1'b1;
          try_wipe         = 1'b1;
          state_d          = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (frame_buffered_i) begin
          cmd_d.retry = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
    end
  end

  assign abort_o              = cmd_q.abort;
  assign retry_o              = cmd_q.retry;
  assign next_frame_o         = cmd_q.next_frame;
  assign invert_fcs_o         = cmd_q.invert_fcs;
  assign inc_lost_carrier_o   = cmd_q.lost_carrier;
  assign inc_late_collision_o = cmd_q.late_col;
  assign inc_underrun_o       = cmd_q.underrun;
  assign normal_collision_o   = cmd_q.normal_col;

  p_late_needs_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inc_late_collision_o |-> $past(half_duplex_i && collision_i));
  p_late_aborts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inc_late_collision_o |-> abort_o);
  p_no_retry_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_late_collision_o && !$past(late_retry_en_i)) |-> (next_frame_o && !retry_o));
  p_retry_next_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry_o && next_frame_o));
  p_underrun_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inc_underrun_o |-> (invert_fcs_o && abort_o));
  p_hold_no_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> !next_frame_o);
  p_lost_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inc_lost_carrier_o |=> !inc_lost_carrier_o);
  p_late_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inc_late_collision_o |=> !inc_late_collision_o);
  p_underrun_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inc_underrun_o |=> !inc_underrun_o);
endmodule

// File: tb/sim_txerr_supervisor.sv
module sim_txerr_supervisor;
  logic clk = 1'b0;
  logic rst_n;
  logic bit_tick_i, preamble_start_i, collision_i, fifo_dry_i;
  logic frame_buffered_i, tx_done_i, link_up_i, half_duplex_i;
  logic late_retry_en_i, underflow_rexmit_en_i;
  logic abort_o, retry_o, next_frame_o, invert_fcs_o;
  logic inc_lost_carrier_o, inc_late_collision_o, inc_underrun_o, normal_collision_o;

  int vectors = 0;
  int fails = 0;
  int tries = 0;
  bit finished = 1'b0;

  // bit order: abort retry next inv lost late under ncol
  localparam logic [7:0] B_ABORT = 8'h80, B_RETRY = 8'h40, B_NEXT = 8'h20, B_INV = 8'h10;
  localparam logic [7:0] B_LOST = 8'h08, B_LATE = 8'h04, B_UNDER = 8'h02, B_NCOL = 8'h01;

  always #10 clk = ~clk;

  txerr_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick_i(bit_tick_i), .preamble_start_i(preamble_start_i),
    .collision_i(collision_i), .fifo_dry_i(fifo_dry_i), .frame_buffered_i(frame_buffered_i),
    .tx_done_i(tx_done_i), .link_up_i(link_up_i), .half_duplex_i(half_duplex_i),
    .late_retry_en_i(late_retry_en_i), .underflow_rexmit_en_i(underflow_rexmit_en_i),
    .abort_o(abort_o), .retry_o(retry_o), .next_frame_o(next_frame_o),
    .invert_fcs_o(invert_fcs_o), .inc_lost_carrier_o(inc_lost_carrier_o),
    .inc_late_collision_o(inc_late_collision_o), .inc_underrun_o(inc_underrun_o),
    .normal_collision_o(normal_collision_o)
  );

  function automatic logic [7:0] outs();
    return {abort_o, retry_o, next_frame_o, invert_fcs_o,
            inc_lost_carrier_o, inc_late_collision_o, inc_underrun_o, normal_collision_o};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs %b, expected %b", req, act, exp);
    end
  endtask

  // drive one input for one cycle, check the registered response and the quiet cycle after
  task automatic fire(input int which, input string req, input logic [7:0] exp);
    @(negedge clk);
    case (which)
      0: collision_i = 1'b1;
      1: fifo_dry_i = 1'b1;
      2: tx_done_i = 1'b1;
      default: frame_buffered_i = 1'b1;
    endcase
    @(negedge clk);
    collision_i = 1'b0; fifo_dry_i = 1'b0; tx_done_i = 1'b0; frame_buffered_i = 1'b0;
    chk(req, outs(), exp);
    @(negedge clk);
    chk("R11", outs(), 8'h00);
  endtask

  task automatic start(input logic link, input string req, input logic [7:0] exp);
    @(negedge clk);
    preamble_start_i = 1'b1; link_up_i = link;
    @(negedge clk);
    preamble_start_i = 1'b0; link_up_i = 1'b1;
    chk(req, outs(), exp);
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      bit_tick_i = 1'b1;
      repeat (n - 1) @(negedge clk);
      @(negedge clk);
      bit_tick_i = 1'b0;
    end
  endtask

  // expected outcome of a late collision under the bench's own attempt model
  function automatic logic [7:0] late_exp(input bit retry_on);
    logic [7:0] e;
    e = B_ABORT | B_LATE;
    if (retry_on && (tries + 1 < 16)) begin
      e |= B_RETRY; tries++;
    end else begin
      e |= B_NEXT; tries = 0;
    end
    return e;
  endfunction

  function automatic int tick_pt(input int i);
    case (i)
      0: return 0;   1: return 1;   2: return 255; 3: return 510;
      4: return 511; 5: return 512; 6: return 513; default: return 600;
    endcase
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: outputs %b, expected completion", outs());
    report();
  end

  initial begin
    rst_n = 1'b0;
    bit_tick_i = 0; preamble_start_i = 0; collision_i = 0; fifo_dry_i = 0;
    frame_buffered_i = 0; tx_done_i = 0; link_up_i = 1; half_duplex_i = 1;
    late_retry_en_i = 0; underflow_rexmit_en_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", outs(), 8'h00);

    // R3/R4/R5/R6/R10: collision timing sweep across duplex and retry settings
    for (int hd = 0; hd < 2; hd++) begin
      for (int re = 0; re < 2; re++) begin
        half_duplex_i = hd[0]; late_retry_en_i = re[0];
        for (int i = 0; i < 8; i++) begin
          int n;
          n = tick_pt(i);
          start(1'b1, "R2 link up", 8'h00);
          ticks(n);
          if (hd == 0) begin
            fire(0, "R3 full duplex ignored", 8'h00);
            fire(2, "R10 done", B_NEXT);
            tries = 0;
          end else if (n < 512) begin
            fire(0, "R3 normal collision", B_NCOL);
          end else begin
            fire(0, re ? "R6 late retry" : "R5 late drop", late_exp(re[0]));
          end
        end
        start(1'b1, "R2 link up", 8'h00);
        fire(2, "R10 done", B_NEXT);
        tries = 0;
      end
    end

    // R6: full attempt budget then reset of the count
    half_duplex_i = 1; late_retry_en_i = 1;
    for (int a = 1; a <= 17; a++) begin
      start(1'b1, "R2 link up", 8'h00);
      ticks(512);
      fire(0, "R6 attempt budget", late_exp(1'b1));
    end
    start(1'b1, "R2 link up", 8'h00);
    fire(2, "R10 done", B_NEXT);
    tries = 0;

    // R2: lost carrier
    start(1'b0, "R2 lost carrier", B_LOST);
    @(negedge clk);
    chk("R11", outs(), 8'h00);
    fire(2, "R10 done", B_NEXT);

    // R7/R8/R9: underflow in both duplex modes
    for (int hd = 0; hd < 2; hd++) begin
      half_duplex_i = hd[0];
      underflow_rexmit_en_i = 0;
      start(1'b1, "R2 link up", 8'h00);
      ticks(20);
      fire(1, "R9 underflow drop", B_ABORT | B_INV | B_UNDER | B_NEXT);
      underflow_rexmit_en_i = 1;
      start(1'b1, "R2 link up", 8'h00);
      ticks(600);
      @(negedge clk);
      fifo_dry_i = 1'b1; collision_i = 1'b1;
      @(negedge clk);
      fifo_dry_i = 1'b0; collision_i = 1'b0;
      chk("R7 underflow priority", outs(), B_ABORT | B_INV | B_UNDER);
      repeat (4) begin
        @(negedge clk);
        chk("R8 waiting", outs(), 8'h00);
      end
      start(1'b0, "R8 start ignored while waiting", 8'h00);
      fire(3, "R8 retransmit", B_RETRY);
      start(1'b1, "R2 link up", 8'h00);
      fire(2, "R10 done", B_NEXT);
    end

    report();
  end
endmodule